// File: doc/BRIEF.md
# 16-bit ALU with Zero/Negative/Carry/Overflow Flag Update

This block is the arithmetic/logic execute unit of a small 16-bit core. It takes a 4-bit function code, the values read from the destination and source registers, and the current value of the flag register. It selects the two operands, computes the result and the zero, negative, carry and overflow flags, and says whether the destination register is to be written. It is purely combinational: the register file around it samples the result and the new flag word on its own clock.

Twelve function codes are defined: add, subtract, and, and-with-complement, or, xor, negate, not, increment, decrement, compare and test. Negate, increment and decrement replace one or both register operands with fixed values. Subtraction reports carry as "no borrow". Compare and test only change the flags. The four remaining codes leave everything untouched. The flags occupy the low four bits of a wider flag register, and the other bits pass through unchanged.

Top module: `alu_nzcv`

## Requirements
- R1: Function 0 (add) yields rd + rs and function 1 (sub) yields rd - rs, both modulo 2^16, on `result_o`.
- R2: Function 2 yields rd & rs, 3 yields rd & ~rs, 4 yields rd | rs, 5 yields rd ^ rs, 7 yields ~rs, and 11 (tst) yields rd & rs.
- R3: Function 6 (neg) yields 0 - rs, function 8 (inc) yields rs + 1 and function 9 (dec) yields rs - 1. The rd value is ignored by all three.
- R4: For functions 0 to 11 the zero flag (flag bit 0) is set exactly when all 16 result bits are zero.
- R5: For functions 0 to 11 the negative flag (flag bit 1) equals result bit 15.
- R6: For add and inc, carry (flag bit 2) is the carry out of bit 15. Overflow (flag bit 3) is set when both operands have the same sign and the result sign differs from it.
- R7: For sub, neg, dec and cmp (function 10, rd - rs), carry is set when no borrow occurs. Overflow is set when the operand signs differ and the result sign equals the sign of the second operand.
- R8: For the logic functions 2, 3, 4, 5, 7 and 11, carry and overflow are cleared.
- R9: `rd_we_o` is high for functions 0 to 9. It is low for cmp and tst, which still update the flags.
- R10: Functions 12 to 15 drive `rd_we_o` low and `result_o` to zero, and `flags_o` equals `flags_i`.
- R11: Flag register bits 15 to 4 always pass from `flags_i` to `flags_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| func_i | input | 4 | Function code |
| rd_val_i | input | 16 | Destination register read value |
| rs_val_i | input | 16 | Source register read value |
| flags_i | input | 16 | Current flag register |
| result_o | output | 16 | Computed result |
| rd_we_o | output | 1 | Destination register write enable |
| flags_o | output | 16 | Next flag register value |

## Verification
Directed vectors exercise the sign and carry boundaries: 0x7FFF+1, 0xFFFF+1, 0x8000-1, negating 0x8000 and 0, decrementing 0, incrementing 0xFFFF, and comparing equal values. These separate the add-style and no-borrow carry rules, and they show which operand's sign the overflow rule compares against. Random vectors across all sixteen codes, each with a random upper flag word, show that operand overrides ignore rd and that the logic ops clear C and V. They also show that compare and test suppress the write and that the unused codes leave the flags alone.

// File: rtl/alu_nzcv_pkg.sv
package alu_nzcv_pkg;

  typedef enum logic [3:0] {
    FN_ADD  = 4'h0,
    FN_SUB  = 4'h1,
    FN_AND  = 4'h2,
    FN_ANDN = 4'h3,
    FN_OR   = 4'h4,
    FN_XOR  = 4'h5,
    FN_NEG  = 4'h6,
    FN_NOT  = 4'h7,
    FN_INC  = 4'h8,
    FN_DEC  = 4'h9,
    FN_CMP  = 4'hA,
    FN_TST  = 4'hB
  } alu_fn_e;

  typedef enum logic [1:0] {
    CLS_ADD   = 2'd0,
    CLS_SUB   = 2'd1,
    CLS_LOGIC = 2'd2,
    CLS_NONE  = 2'd3
  } alu_cls_e;

  localparam int FLAG_Z = 0;
  localparam int FLAG_N = 1;
  localparam int FLAG_C = 2;
  localparam int FLAG_V = 3;
  localparam int NUM_FLAGS = 4;

  function automatic alu_cls_e fn_class(input logic [3:0] fn);
    case (fn)
      FN_ADD, FN_INC:                 fn_class = CLS_ADD;
      FN_SUB, FN_NEG, FN_DEC, FN_CMP: fn_class = CLS_SUB;
      FN_AND, FN_ANDN, FN_OR, FN_XOR,
      FN_NOT, FN_TST:                 fn_class = CLS_LOGIC;
      default:                        fn_class = CLS_NONE;
    endcase
  endfunction

  function automatic logic fn_writes_rd(input logic [3:0] fn);
    fn_writes_rd = (fn <= FN_DEC);
  endfunction

endpackage

// File: rtl/alu_opsel.sv
module alu_opsel
  import alu_nzcv_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [3:0]        func_i,
  input  logic [DATA_W-1:0] rd_val_i,
  input  logic [DATA_W-1:0] rs_val_i,
  output logic [DATA_W-1:0] op_a_o,
  output logic [DATA_W-1:0] op_b_o
);

  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  always_comb begin
    op_a_o = rd_val_i;
    op_b_o = rs_val_i;
    case (func_i)
      FN_NEG: op_a_o = '0;
      FN_INC, FN_DEC: begin
        op_a_o = rs_val_i;
        op_b_o = ONE;
      end
      default: ;
    endcase
  end

  // R3: the fixed-operand codes never take rd
  always_comb begin
    if (func_i == FN_INC || func_i == FN_DEC)
      assert_incdec_const_R3: assert (op_b_o == ONE && op_a_o == rs_val_i)
        else $error("inc/dec operand override broken");
  end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_nzcv_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [3:0]        func_i,
  input  logic [DATA_W-1:0] op_a_i,
  input  logic [DATA_W-1:0] op_b_i,
  output logic [DATA_W-1:0] res_o,
  output logic              carry_o,
  output logic              ovf_o
);

  localparam int MSB = DATA_W - 1;

  alu_cls_e          cls;
  logic [DATA_W:0]   sum_ext;
  logic              sa, sb, sr;

  assign cls = fn_class(func_i);
  assign sa  = op_a_i[MSB];
  assign sb  = op_b_i[MSB];

  always_comb begin
    sum_ext = '0;
    res_o   = '0;
    case (cls)
      CLS_ADD: begin
        sum_ext = {1'b0, op_a_i} + {1'b0, op_b_i};
        res_o   = sum_ext[MSB:0];
      end
      CLS_SUB: begin
        sum_ext = {1'b0, op_a_i} - {1'b0, op_b_i};
        res_o   = sum_ext[MSB:0];
      end
      CLS_LOGIC: begin
        case (func_i)
          FN_AND, FN_TST: res_o = op_a_i & op_b_i;
          FN_ANDN:        res_o = op_a_i & ~op_b_i;
          FN_OR:          res_o = op_a_i | op_b_i;
          FN_XOR:         res_o = op_a_i ^ op_b_i;
          FN_NOT:         res_o = ~op_b_i;
          default:        res_o = '0;
        endcase
      end
      default: res_o = '0;
    endcase
  end

  assign sr = res_o[MSB];

  always_comb begin
    carry_o = 1'b0;
    ovf_o   = 1'b0;
    case (cls)
      CLS_ADD: begin
        carry_o = sum_ext[DATA_W];
        ovf_o   = (sa == sb) && (sr != sb);
      end
      CLS_SUB: begin
        carry_o = ~sum_ext[DATA_W];  // set when no borrow
        ovf_o   = (sa != sb) && (sr == sb);
      end
      default: ;
    endcase
  end

  // R6: an add that overflows had like-signed operands
  always_comb begin
    if (cls == CLS_ADD && ovf_o)
      assert_add_ovf_sign_R6: assert (op_a_i[MSB] == op_b_i[MSB])
        else $error("add overflow with unlike operand signs");
  end

  // R7: a subtract with no borrow means a >= b unsigned
  always_comb begin
    if (cls == CLS_SUB)
      assert_sub_noborrow_R7: assert (carry_o == (op_a_i >= op_b_i))
        else $error("sub carry disagrees with unsigned compare");
  end

endmodule

// File: rtl/alu_flag_merge.sv
module alu_flag_merge
  import alu_nzcv_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int FLAG_W = 16
) (
  input  logic [3:0]        func_i,
  input  logic [DATA_W-1:0] res_i,
  input  logic              carry_i,
  input  logic              ovf_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic [FLAG_W-1:0] flags_o,
  output logic              rd_we_o
);

  localparam int MSB = DATA_W - 1;

  logic upd;

  assign upd     = (fn_class(func_i) != CLS_NONE);
  assign rd_we_o = fn_writes_rd(func_i);

  always_comb begin
    flags_o = flags_i;
    if (upd) begin
      flags_o[FLAG_Z] = ~|res_i;
      flags_o[FLAG_N] = res_i[MSB];
      flags_o[FLAG_C] = carry_i;
      flags_o[FLAG_V] = ovf_i;
    end
  end

  // R8: logic ops leave C and V clear
  always_comb begin
    if (fn_class(func_i) == CLS_LOGIC)
      assert_logic_clears_cv_R8: assert (!flags_o[FLAG_C] && !flags_o[FLAG_V])
        else $error("logic op left C or V set");
  end

endmodule

// File: rtl/alu_nzcv.sv
module alu_nzcv
  import alu_nzcv_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int FLAG_W = 16
) (
  input  logic [3:0]        func_i,
  input  logic [DATA_W-1:0] rd_val_i,
  input  logic [DATA_W-1:0] rs_val_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic [DATA_W-1:0] result_o,
  output logic              rd_we_o,
  output logic [FLAG_W-1:0] flags_o
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] op_a, op_b;
  logic              carry, ovf;

  alu_opsel #(.DATA_W(DATA_W)) i_opsel (
    .func_i   (func_i),
    .rd_val_i (rd_val_i),
    .rs_val_i (rs_val_i),
    .op_a_o   (op_a),
    .op_b_o   (op_b)
  );

  alu_datapath #(.DATA_W(DATA_W)) i_datapath (
    .func_i  (func_i),
    .op_a_i  (op_a),
    .op_b_i  (op_b),
    .res_o   (result_o),
    .carry_o (carry),
    .ovf_o   (ovf)
  );

  alu_flag_merge #(.DATA_W(DATA_W), .FLAG_W(FLAG_W)) i_flags (
    .func_i  (func_i),
    .res_i   (result_o),
    .carry_i (carry),
    .ovf_i   (ovf),
    .flags_i (flags_i),
    .flags_o (flags_o),
    .rd_we_o (rd_we_o)
  );

  always_comb begin
    if (func_i <= FN_TST) begin
      assert_zero_flag_R4: assert (flags_o[FLAG_Z] == (result_o == '0))
        else $error("Z does not follow result");
      assert_neg_flag_R5: assert (flags_o[FLAG_N] == result_o[MSB])
        else $error("N does not follow result");
    end
  end

  always_comb begin
    if (func_i == FN_CMP || func_i == FN_TST)
      assert_no_write_cmp_R9: assert (!rd_we_o)
        else $error("cmp/tst requested rd write");
  end

  always_comb begin
    if (func_i > FN_TST)
      assert_idle_code_R10: assert (!rd_we_o && flags_o == flags_i && result_o == '0)
        else $error("unused code had an effect");
  end

  always_comb begin
    assert_upper_flags_R11: assert (flags_o[FLAG_W-1:NUM_FLAGS] == flags_i[FLAG_W-1:NUM_FLAGS])
      else $error("upper flag bits changed");
  end

endmodule

// File: tb/test_alu_nzcv.sv
module test_alu_nzcv;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  func;
  logic [15:0] rd_val, rs_val, flags_in;
  logic [15:0] result;
  logic        rd_we;
  logic [15:0] flags_out;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  alu_nzcv i_alu_nzcv (
    .func_i   (func),
    .rd_val_i (rd_val),
    .rs_val_i (rs_val),
    .flags_i  (flags_in),
    .result_o (result),
    .rd_we_o  (rd_we),
    .flags_o  (flags_out)
  );

  function automatic void model(input logic [3:0] f, input logic [15:0] rd, input logic [15:0] rs,
                                input logic [15:0] fl, output logic [15:0] r, output logic we,
                                output logic [15:0] fo);
    logic [15:0] a, b;
    logic [16:0] s;
    logic c, v;
    a = rd; b = rs; c = 1'b0; v = 1'b0; r = 16'h0;
    if (f == 4'h6) a = 16'h0;
    if (f == 4'h8 || f == 4'h9) begin a = rs; b = 16'h1; end
    case (f)
      4'h0, 4'h8: begin
        s = {1'b0, a} + {1'b0, b}; r = s[15:0]; c = s[16];
        v = (a[15] == b[15]) && (r[15] != b[15]);
      end
      4'h1, 4'h6, 4'h9, 4'hA: begin
        s = {1'b0, a} - {1'b0, b}; r = s[15:0]; c = ~s[16];
        v = (a[15] != b[15]) && (r[15] == b[15]);
      end
      4'h2, 4'hB: r = a & b;
      4'h3:       r = a & ~b;
      4'h4:       r = a | b;
      4'h5:       r = a ^ b;
      4'h7:       r = ~b;
      default:    r = 16'h0;
    endcase
    we = (f <= 4'h9);
    fo = fl;
    if (f <= 4'hB) begin
      fo[0] = (r == 16'h0);
      fo[1] = r[15];
      fo[2] = c;
      fo[3] = v;
    end
  endfunction

  function automatic string res_tag(input logic [3:0] f);
    case (f)
      4'h0, 4'h1:             res_tag = "R1";
      4'h6, 4'h8, 4'h9:       res_tag = "R3";
      4'hA:                   res_tag = "R7";
      4'hC, 4'hD, 4'hE, 4'hF: res_tag = "R10";
      default:                res_tag = "R2";
    endcase
  endfunction

  function automatic string cv_tag(input logic [3:0] f);
    case (f)
      4'h0, 4'h8:             cv_tag = "R6";
      4'h1, 4'h6, 4'h9, 4'hA: cv_tag = "R7";
      4'hC, 4'hD, 4'hE, 4'hF: cv_tag = "R10";
      default:                cv_tag = "R8";
    endcase
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s func=%h rd=%h rs=%h fl=%h: actual %h expected %h",
               tag, func, rd_val, rs_val, flags_in, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] f, input logic [15:0] rd, input logic [15:0] rs,
                       input logic [15:0] fl);
    logic [15:0] er, efo;
    logic ewe;
    @(negedge clk);
    func = f; rd_val = rd; rs_val = rs; flags_in = fl;
    #2;
    model(f, rd, rs, fl, er, ewe, efo);
    check(res_tag(f), result, er);
    check((f > 4'hB) ? "R10" : "R9", {15'h0, rd_we}, {15'h0, ewe});
    if (f <= 4'hB) begin
      check("R4", {15'h0, flags_out[0]}, {15'h0, efo[0]});
      check("R5", {15'h0, flags_out[1]}, {15'h0, efo[1]});
    end else begin
      check("R10", flags_out[3:0], efo[3:0]);
    end
    check(cv_tag(f), {14'h0, flags_out[3:2]}, {14'h0, efo[3:2]});
    check("R11", {4'h0, flags_out[15:4]}, {4'h0, efo[15:4]});
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    func = 4'h0; rd_val = 16'h0; rs_val = 16'h0; flags_in = 16'h0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // reset state: idle inputs give add of zeros
    #2;
    check("R4", {15'h0, flags_out[0]}, 16'h1);
    check("R1", result, 16'h0);

    // R6 boundaries
    apply(4'h0, 16'h7FFF, 16'h0001, 16'hA5F0);
    apply(4'h0, 16'hFFFF, 16'h0001, 16'h0000);
    apply(4'h0, 16'h8000, 16'h8000, 16'h000F);
    apply(4'h8, 16'h1234, 16'hFFFF, 16'h0000);
    apply(4'h8, 16'hDEAD, 16'h7FFF, 16'h0000);
    // R7 boundaries
    apply(4'h1, 16'h8000, 16'h0001, 16'h0000);
    apply(4'h1, 16'h0000, 16'h0001, 16'h0000);
    apply(4'h1, 16'h5555, 16'h5555, 16'h000F);
    apply(4'h6, 16'hBEEF, 16'h8000, 16'h0000);
    apply(4'h6, 16'hBEEF, 16'h0000, 16'h0000);
    apply(4'h9, 16'h4321, 16'h0000, 16'h0000);
    apply(4'h9, 16'h4321, 16'h8000, 16'h0000);
    // R9 cmp/tst
    apply(4'hA, 16'h1111, 16'h1111, 16'hFFF0);
    apply(4'hA, 16'h0001, 16'h0002, 16'h0000);
    apply(4'hB, 16'hF0F0, 16'h0F0F, 16'h0000);
    apply(4'hB, 16'h8001, 16'h8000, 16'h000F);
    // R8 logic ops with C and V previously set
    for (int f = 2; f <= 7; f++) if (f != 6) apply(4'(f), 16'hC3A5, 16'h5A3C, 16'h000C);
    // R10 unused codes
    for (int f = 12; f <= 15; f++) apply(4'(f), 16'h0000, 16'hFFFF, 16'h9ABC);

    for (int i = 0; i < 3000; i++)
      apply(4'($urandom), 16'($urandom), 16'($urandom), 16'($urandom));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule